// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller with Acknowledge Sequencer

This block joins two 8-input interrupt controller cores, a primary and a secondary, into one 16-line interrupt system. A byte-wide I/O access port reaches the command and data registers of each core and a pair of trigger-mode registers. The resolved request of the secondary is fed into input 2 of the primary as a pulse, so that a secondary request becomes a single edge-latched pending bit on the primary. The primary's resolved request drives the processor interrupt line.

The processor runs an acknowledge cycle by raising a one-cycle strobe. In the next cycle the block returns an 8-bit vector, a valid flag and the global line number. A request reached through input 2 is resolved in the secondary and acknowledged in both cores. When no core has a request to give, the spurious vector (base + 7) of the relevant core is returned. A poll read made through the secondary also clears the cascade bit in the primary. Accesses wider than one byte are dropped.

Each core latches edge inputs on a rising edge and follows level inputs. Lower input numbers have higher priority, shifted by a rotation offset. A request is blocked by an in-service entry of the same or higher priority. Each core supports non-specific, specific and rotating end-of-interrupt commands, automatic end-of-interrupt, a register read select and a poll command.

Top module: `pic_cascade_top`

## Requirements
- R1: Byte accesses at 0x20/0x21 reach the primary core and 0xA0/0xA1 reach the secondary core. Address bit 0 = 0 is the command port and bit 0 = 1 the data port. A read on the data port in the running state returns the mask register. 0x4D0 and 0x4D1 reach the primary and secondary trigger-mode registers. Read data is presented with `bus_rvalid_o` one cycle after the request.
- R2: An access whose `bus_len_i` is not 1 changes no state. If it is a read, it returns 0x00.
- R3: The trigger-mode registers keep only the writable bits: 0xF8 for the primary and 0xDE for the secondary. Other bits read back as 0.
- R4: An input whose trigger bit is 0 sets its pending bit on a rising edge, and the bit stays set until it is acknowledged or polled. An input whose trigger bit is 1 has a pending bit that follows the line.
- R5: While the secondary has a resolved request, pending bit 2 of the primary becomes set. The only exception is a cycle with an acknowledge or a secondary poll hit; in that cycle the bit is not set.
- R6: An acknowledge when the primary has no resolved request returns vector primary_base*8+7 with line 7, and changes no state.
- R7: An acknowledge of a primary line n other than 2 returns vector primary_base*8+n with line n. It sets in-service bit n and clears pending bit n if that input is edge-triggered. The vector is valid on the cycle after the strobe.
- R8: An acknowledge that resolves primary line 2 while the secondary resolves line m returns secondary_base*8+m with global line m+8. It sets in-service bit 2 in the primary and bit m in the secondary.
- R9: An acknowledge that resolves primary line 2 while the secondary has no request returns secondary_base*8+7 with line 15. It leaves the secondary unchanged.
- R10: The highest-priority pending, unmasked input is lowest-numbered when the rotation offset is 0. It is reported only if it is above every in-service entry. Command 0x20 clears the highest-priority in-service bit. Command 0x60|n clears in-service bit n.
- R11: Command 0x0C arms a poll, and command 0x0A/0x0B selects pending/in-service for command-port reads. The next command-port read of an armed poll returns the resolved line number, or 7 if there is none, and clears that line's pending and in-service bits. A poll hit through the secondary also clears pending and in-service bit 2 of the primary.
- R12: `intr_o` is 0 after reset. It shows the primary's resolved request one cycle after the state that produced it.
- R13: A command-port write with bit 4 set starts initialisation. It clears mask, in-service, edge pending bits and rotation. The following data writes are: the base (bits 7:3), a cascade byte, and, if bit 0 of the start byte was set, a mode byte whose bit 1 enables automatic end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Interrupt lines; 0-7 primary, 8-15 secondary |
| bus_valid_i | input | 1 | Access request strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | I/O address |
| bus_len_i | input | 3 | Access width in bytes |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| vec_o | output | 8 | Acknowledge vector |
| vec_valid_o | output | 1 | Vector valid |
| vec_irq_o | output | 4 | Global line number of the acknowledge |
| intr_o | output | 1 | Interrupt request to the processor |

## Verification
Two functions can fall in the same cycle: an acknowledge strobe, which clears primary pending bit 2, and the cascade pulse that the secondary's remaining request drives into that same bit. The bench provokes this case in three steps. Both cores are put in automatic end-of-interrupt mode, with two secondary lines pending together. Two acknowledge strobes are then issued in consecutive cycles. The outcome is judged from the vector sequence: the secondary's first vector, then the primary's spurious vector 7 (the bit has not yet been re-latched), then, at a later acknowledge, the secondary's second vector.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  localparam int unsigned NLINE = 8;
  localparam int unsigned IDW   = $clog2(NLINE);
  localparam int unsigned CASC_LINE = 2;

  localparam int unsigned SEL_PRI = 0;
  localparam int unsigned SEL_SEC = 1;
  localparam int unsigned SEL_TP  = 2;
  localparam int unsigned SEL_TS  = 3;
  localparam int unsigned NSEL    = 4;

  typedef enum logic [1:0] {IST_RUN, IST_BASE, IST_CASC, IST_MODE} ist_e;

  typedef struct packed {
    logic [NLINE-1:0] irr;
    logic [NLINE-1:0] imr;
    logic [NLINE-1:0] isr;
    logic [NLINE-1:0] last;
    logic [NLINE-1:0] trig;
    logic [7-IDW:0]   base;
    logic [IDW-1:0]   padd;
    logic             rrs;
    logic             poll;
    logic             aeoi;
    logic             init4;
    ist_e             ist;
  } core_st_t;

  // rank of the best set bit relative to the rotation offset; NLINE if none
  function automatic logic [IDW:0] prio_of(input logic [NLINE-1:0] m,
                                           input logic [IDW-1:0] padd);
    logic [IDW:0] r;
    r = (IDW+1)'(NLINE);
    for (int k = NLINE-1; k >= 0; k--)
      if (m[IDW'(k) + padd]) r = (IDW+1)'(k);
    return r;
  endfunction
endpackage

// File: rtl/pic_decode.sv
module pic_decode
  import pic_cascade_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 3,
  parameter logic [ADDR_W-1:0] PRI_ADDR  = 'h20,
  parameter logic [ADDR_W-1:0] SEC_ADDR  = 'hA0,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 'h4D0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [NSEL-1:0]   sel_o,
  output logic              a0_o,
  output logic              byte_o
);
  logic hit_pri, hit_sec, hit_trig;

  assign hit_pri  = addr_i[ADDR_W-1:1] == PRI_ADDR[ADDR_W-1:1];
  assign hit_sec  = addr_i[ADDR_W-1:1] == SEC_ADDR[ADDR_W-1:1];
  assign hit_trig = addr_i[ADDR_W-1:1] == TRIG_ADDR[ADDR_W-1:1];
  assign a0_o     = addr_i[0];
  assign byte_o   = len_i == LEN_W'(1);

  always_comb begin
    sel_o          = '0;
    sel_o[SEL_PRI] = hit_pri;
    sel_o[SEL_SEC] = hit_sec;
    sel_o[SEL_TP]  = hit_trig & ~addr_i[0];
    sel_o[SEL_TS]  = hit_trig &  addr_i[0];
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_cascade_pkg::*;
#(
  parameter logic [NLINE-1:0] TRIG_MASK = 8'hF8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLINE-1:0] line_i,
  input  logic [NLINE-1:0] pulse_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             a0_i,
  input  logic [7:0]       wdata_i,
  input  logic             trig_wr_i,
  input  logic             ack_i,
  input  logic             casc_clr_i,
  output logic             req_o,
  output logic [IDW-1:0]   req_id_o,
  output logic [7-IDW:0]   base_o,
  output logic [7:0]       rdata_o,
  output logic [NLINE-1:0] trig_o,
  output logic             poll_hit_o
);
  core_st_t q, n;
  logic [IDW:0]   pend_p, isr_p;
  logic [IDW-1:0] eoi_id;
  logic [NLINE-1:0] id_oh;

  assign pend_p   = prio_of(q.irr & ~q.imr, q.padd);
  assign isr_p    = prio_of(q.isr, q.padd);
  assign req_o    = pend_p < isr_p;
  assign req_id_o = pend_p[IDW-1:0] + q.padd;
  assign eoi_id   = isr_p[IDW-1:0] + q.padd;
  assign id_oh    = NLINE'(1) << req_id_o;
  assign base_o   = q.base;
  assign trig_o   = q.trig;
  assign poll_hit_o = q.poll & req_o;

  always_comb begin
    if (q.poll)     rdata_o = req_o ? 8'(req_id_o) : 8'(NLINE-1);
    else if (a0_i)  rdata_o = q.imr;
    else if (q.rrs) rdata_o = q.isr;
    else            rdata_o = q.irr;
  end

  always_comb begin
    n = q;
    // acknowledge
    if (ack_i && req_o) begin
      n.isr[req_id_o] = 1'b1;
      if (!q.trig[req_id_o]) n.irr[req_id_o] = 1'b0;
      if (q.aeoi) n.isr[req_id_o] = 1'b0;
    end
    // input sampling
    for (int i = 0; i < NLINE; i++) begin
      if (q.trig[i])                  n.irr[i] = line_i[i];
      else if (line_i[i] && !q.last[i]) n.irr[i] = 1'b1;
      if (pulse_i[i]) n.irr[i] = 1'b1;
    end
    n.last = line_i;
    if (casc_clr_i) begin
      n.irr[CASC_LINE] = 1'b0;
      n.isr[CASC_LINE] = 1'b0;
    end
    // poll read consumes the resolved line
    if (rd_i && q.poll) begin
      n.poll = 1'b0;
      if (req_o) begin
        n.irr[req_id_o] = 1'b0;
        n.isr[req_id_o] = 1'b0;
      end
    end
    if (wr_i && !a0_i) begin
      if (wdata_i[4]) begin
        n.init4 = wdata_i[0];
        n.irr   = n.irr & q.trig;
        n.imr   = '0;
        n.isr   = '0;
        n.padd  = '0;
        n.rrs   = 1'b0;
        n.poll  = 1'b0;
        if (!wdata_i[0]) n.aeoi = 1'b0;
        n.ist   = IST_BASE;
      end else if (wdata_i[3]) begin
        if (wdata_i[2]) n.poll = 1'b1;
        if (wdata_i[1]) n.rrs  = wdata_i[0];
      end else begin
        unique case (wdata_i[7:5])
          3'd1, 3'd5: if (isr_p != (IDW+1)'(NLINE)) begin
            n.isr[eoi_id] = 1'b0;
            if (wdata_i[7]) n.padd = eoi_id + IDW'(1);
          end
          3'd3: n.isr[wdata_i[IDW-1:0]] = 1'b0;
          3'd6: n.padd = wdata_i[IDW-1:0] + IDW'(1);
          3'd7: begin
            n.isr[wdata_i[IDW-1:0]] = 1'b0;
            n.padd = wdata_i[IDW-1:0] + IDW'(1);
          end
          default: ;
        endcase
      end
    end else if (wr_i) begin
      unique case (q.ist)
        IST_RUN:  n.imr = wdata_i;
        IST_BASE: begin n.base = wdata_i[7:IDW]; n.ist = IST_CASC; end
        IST_CASC: n.ist = q.init4 ? IST_MODE : IST_RUN;
        IST_MODE: begin n.aeoi = wdata_i[1]; n.ist = IST_RUN; end
        default:  n.ist = IST_RUN;
      endcase
    end
    if (trig_wr_i) n.trig = wdata_i & TRIG_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= n;

  // R7: an acknowledged line is in service on the next cycle
  a_r7_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o && !q.aeoi && !wr_i && !rd_i && !casc_clr_i)
      |=> (q.isr & $past(id_oh)) != '0);

  // R3: non-writable trigger bits never set
  a_r3_trig_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr_i |=> (trig_o & ~TRIG_MASK) == '0);
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top
  import pic_cascade_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 3,
  parameter logic [NLINE-1:0] PRI_TRIG_MASK = 8'hF8,
  parameter logic [NLINE-1:0] SEC_TRIG_MASK = 8'hDE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2*NLINE-1:0] irq_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [LEN_W-1:0]  bus_len_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic              inta_i,
  output logic [7:0]        vec_o,
  output logic              vec_valid_o,
  output logic [IDW:0]      vec_irq_o,
  output logic              intr_o
);
  logic [NSEL-1:0] sel;
  logic a0, byte_ok, wr, rd;
  logic p_req, s_req, s_poll_hit, s_casc_clr, s_ack;
  logic [IDW-1:0] p_id, s_id;
  logic [7-IDW:0] p_base, s_base;
  logic [7:0] p_rdata, s_rdata, rd_mux, vec_d;
  logic [NLINE-1:0] p_trig, s_trig, p_pulse;
  logic [IDW:0] irq_d;
  logic [7:0] rdata_q, vec_q;
  logic rvalid_q, vvalid_q, intr_q;
  logic [IDW:0] virq_q;

  pic_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .addr_i(bus_addr_i), .len_i(bus_len_i),
    .sel_o(sel), .a0_o(a0), .byte_o(byte_ok));

  assign wr = bus_valid_i & bus_write_i & byte_ok;
  assign rd = bus_valid_i & ~bus_write_i & byte_ok;
  assign s_ack      = inta_i & p_req & (p_id == IDW'(CASC_LINE));
  assign s_casc_clr = rd & sel[SEL_SEC] & s_poll_hit;

  // cascade pulse; suppressed while the primary bit is being consumed
  always_comb begin
    p_pulse = '0;
    p_pulse[CASC_LINE] = s_req & ~inta_i & ~s_casc_clr;
  end

  pic_core #(.TRIG_MASK(PRI_TRIG_MASK)) u_pri (
    .clk_i, .rst_ni,
    .line_i(irq_i[NLINE-1:0]), .pulse_i(p_pulse),
    .wr_i(wr & sel[SEL_PRI]), .rd_i(rd & sel[SEL_PRI]), .a0_i(a0),
    .wdata_i(bus_wdata_i), .trig_wr_i(wr & sel[SEL_TP]),
    .ack_i(inta_i), .casc_clr_i(s_casc_clr),
    .req_o(p_req), .req_id_o(p_id), .base_o(p_base), .rdata_o(p_rdata),
    .trig_o(p_trig), .poll_hit_o());

  pic_core #(.TRIG_MASK(SEC_TRIG_MASK)) u_sec (
    .clk_i, .rst_ni,
    .line_i(irq_i[2*NLINE-1:NLINE]), .pulse_i('0),
    .wr_i(wr & sel[SEL_SEC]), .rd_i(rd & sel[SEL_SEC]), .a0_i(a0),
    .wdata_i(bus_wdata_i), .trig_wr_i(wr & sel[SEL_TS]),
    .ack_i(s_ack), .casc_clr_i(1'b0),
    .req_o(s_req), .req_id_o(s_id), .base_o(s_base), .rdata_o(s_rdata),
    .trig_o(s_trig), .poll_hit_o(s_poll_hit));

  always_comb begin
    if (!byte_ok)          rd_mux = '0;
    else if (sel[SEL_PRI]) rd_mux = p_rdata;
    else if (sel[SEL_SEC]) rd_mux = s_rdata;
    else if (sel[SEL_TP])  rd_mux = p_trig;
    else if (sel[SEL_TS])  rd_mux = s_trig;
    else                   rd_mux = '0;
  end

  always_comb begin
    if (!p_req) begin
      vec_d = {p_base, IDW'(NLINE-1)};
      irq_d = (IDW+1)'(NLINE-1);
    end else if (p_id != IDW'(CASC_LINE)) begin
      vec_d = {p_base, p_id};
      irq_d = {1'b0, p_id};
    end else if (s_req) begin
      vec_d = {s_base, s_id};
      irq_d = {1'b1, s_id};
    end else begin
      vec_d = {s_base, IDW'(NLINE-1)};
      irq_d = (IDW+1)'(2*NLINE-1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_q <= '0; rvalid_q <= 1'b0;
      vec_q <= '0; virq_q <= '0; vvalid_q <= 1'b0; intr_q <= 1'b0;
    end else begin
      rvalid_q <= bus_valid_i & ~bus_write_i;
      if (bus_valid_i & ~bus_write_i) rdata_q <= rd_mux;
      vvalid_q <= inta_i;
      if (inta_i) begin vec_q <= vec_d; virq_q <= irq_d; end
      intr_q <= p_req;
    end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign vec_o        = vec_q;
  assign vec_irq_o    = virq_q;
  assign vec_valid_o  = vvalid_q;
  assign intr_o       = intr_q;

  a_r7_vec_follows_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vec_valid_o);
  a_r6_spurious_primary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !p_req) |=> (vec_irq_o == (IDW+1)'(NLINE-1)) && (vec_o[IDW-1:0] == IDW'(NLINE-1)));
  a_r9_spurious_secondary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ack && !s_req) |=> vec_irq_o == (IDW+1)'(2*NLINE-1));
  a_r2_wide_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i && bus_len_i != LEN_W'(1)) |=> (bus_rvalid_o && bus_rdata_o == 8'h00));
endmodule

// File: tb/pic_cascade_top_tb.sv
`timescale 1ns/1ps
module pic_cascade_top_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] irq_i = '0;
  logic bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [2:0] bus_len_i = 3'd1;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic bus_rvalid_o;
  logic inta_i = 1'b0;
  logic [7:0] vec_o;
  logic vec_valid_o;
  logic [3:0] vec_irq_o;
  logic intr_o;

  int ncmp = 0, nbad = 0;
  logic [7:0]  rd_q[$];
  string       rd_tag[$];
  logic [11:0] vec_q[$];
  string       vec_tag[$];

  always #2 clk_i = ~clk_i;

  pic_cascade_top u_dut (.*);

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bw(input logic [15:0] a, input logic [7:0] d, input logic [2:0] len);
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; bus_len_i = len;
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_len_i = 3'd1;
  endtask

  task automatic br(input logic [15:0] a, input logic [7:0] exp, input string tag, input logic [2:0] len);
    @(negedge clk_i);
    rd_q.push_back(exp); rd_tag.push_back(tag);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a; bus_len_i = len;
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_len_i = 3'd1;
  endtask

  task automatic ak(input int n, input logic [7:0] v0, input logic [3:0] i0,
                    input logic [7:0] v1, input logic [3:0] i1, input string tag);
    @(negedge clk_i);
    vec_q.push_back({i0, v0}); vec_tag.push_back(tag);
    if (n > 1) begin vec_q.push_back({i1, v1}); vec_tag.push_back(tag); end
    inta_i = 1'b1;
    repeat (n) @(negedge clk_i);
    inta_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (bus_rvalid_o) begin
      if (rd_q.size() == 0) chk("R1 unexpected read", 12'(bus_rdata_o), 12'hFFF);
      else chk(rd_tag.pop_front(), 12'(bus_rdata_o), 12'(rd_q.pop_front()));
    end
    if (vec_valid_o) begin
      if (vec_q.size() == 0) chk("R7 unexpected vector", {vec_irq_o, vec_o}, 12'hFFF);
      else chk(vec_tag.pop_front(), {vec_irq_o, vec_o}, vec_q.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    nbad++; ncmp++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  task automatic init(input logic [7:0] mode);
    bw(16'h20, 8'h11, 1); bw(16'h21, 8'h08, 1); bw(16'h21, 8'h04, 1); bw(16'h21, mode, 1);
    bw(16'hA0, 8'h11, 1); bw(16'hA1, 8'h70, 1); bw(16'hA1, 8'h02, 1); bw(16'hA1, mode, 1);
  endtask

  initial begin
    idle(3);
    chk("R12 reset intr", 12'(intr_o), 12'h0);
    chk("R7 reset vec_valid", 12'(vec_valid_o), 12'h0);
    chk("R1 reset rvalid", 12'(bus_rvalid_o), 12'h0);
    rst_ni = 1'b1;
    idle(2);
    br(16'h21, 8'h00, "R1 reset mask", 1);
    init(8'h01);
    bw(16'h21, 8'hA5, 1); br(16'h21, 8'hA5, "R13 R1 primary mask", 1);
    bw(16'hA1, 8'h3C, 1); br(16'hA1, 8'h3C, "R1 secondary mask", 1);
    bw(16'hA1, 8'h00, 1);
    // R3
    bw(16'h4D0, 8'hFF, 1); br(16'h4D0, 8'hF8, "R3 primary trigger", 1);
    bw(16'h4D1, 8'hFF, 1); br(16'h4D1, 8'hDE, "R3 secondary trigger", 1);
    bw(16'h4D0, 8'h00, 1); bw(16'h4D1, 8'h00, 1);
    // R2
    bw(16'h21, 8'h80, 1);
    bw(16'h21, 8'h00, 2);
    br(16'h21, 8'h00, "R2 wide read zero", 2);
    br(16'h21, 8'h80, "R2 wide write ignored", 1);
    bw(16'h21, 8'h00, 1);
    // R6
    ak(1, 8'h0F, 4'd7, 8'h00, 4'd0, "R6 spurious primary");
    br(16'h20, 8'h00, "R6 pending unchanged", 1);
    bw(16'h20, 8'h0B, 1); br(16'h20, 8'h00, "R6 in-service unchanged", 1);
    bw(16'h20, 8'h0A, 1);
    // R4 R7 edge line 5
    irq_i[5] = 1'b1; idle(3);
    br(16'h20, 8'h20, "R4 edge latched", 1);
    chk("R12 intr high", 12'(intr_o), 12'h1);
    ak(1, 8'h0D, 4'd5, 8'h00, 4'd0, "R7 ack line 5");
    br(16'h20, 8'h00, "R4 R7 edge pending cleared", 1);
    bw(16'h20, 8'h0B, 1); br(16'h20, 8'h20, "R7 in-service set", 1);
    idle(2);
    chk("R12 intr low after ack", 12'(intr_o), 12'h0);
    // R10 priority
    irq_i[6] = 1'b1; idle(3);
    chk("R10 lower blocked", 12'(intr_o), 12'h0);
    irq_i[3] = 1'b1; idle(3);
    chk("R10 higher reported", 12'(intr_o), 12'h1);
    ak(1, 8'h0B, 4'd3, 8'h00, 4'd0, "R10 ack line 3");
    bw(16'h20, 8'h20, 1); br(16'h20, 8'h20, "R10 nonspecific eoi", 1);
    idle(2);
    chk("R10 still blocked", 12'(intr_o), 12'h0);
    bw(16'h20, 8'h65, 1); br(16'h20, 8'h00, "R10 specific eoi", 1);
    idle(2);
    ak(1, 8'h0E, 4'd6, 8'h00, 4'd0, "R10 ack line 6");
    bw(16'h20, 8'h20, 1);
    irq_i[3] = 1'b0; irq_i[5] = 1'b0; irq_i[6] = 1'b0;
    bw(16'h20, 8'h0A, 1); br(16'h20, 8'h00, "R11 pending select", 1);
    // R4 level
    bw(16'h4D0, 8'h08, 1);
    irq_i[3] = 1'b1; idle(2);
    br(16'h20, 8'h08, "R4 level follows high", 1);
    irq_i[3] = 1'b0; idle(2);
    br(16'h20, 8'h00, "R4 level follows low", 1);
    idle(1);
    chk("R12 intr low", 12'(intr_o), 12'h0);
    bw(16'h4D0, 8'h00, 1);
    // R5 R8
    irq_i[12] = 1'b1; idle(4);
    br(16'h20, 8'h04, "R5 cascade pending", 1);
    br(16'hA0, 8'h10, "R5 secondary pending", 1);
    ak(1, 8'h74, 4'd12, 8'h00, 4'd0, "R8 cascaded ack");
    bw(16'hA0, 8'h0B, 1); br(16'hA0, 8'h10, "R8 secondary in-service", 1);
    bw(16'h20, 8'h0B, 1); br(16'h20, 8'h04, "R8 primary in-service", 1);
    bw(16'hA0, 8'h20, 1); bw(16'h20, 8'h20, 1);
    irq_i[12] = 1'b0;
    // R9
    irq_i[9] = 1'b1; idle(4);
    bw(16'hA1, 8'h02, 1); idle(2);
    ak(1, 8'h77, 4'd15, 8'h00, 4'd0, "R9 secondary spurious");
    br(16'hA0, 8'h00, "R9 secondary untouched", 1);
    bw(16'h20, 8'h20, 1);
    bw(16'hA1, 8'h00, 1);
    irq_i[9] = 1'b0; idle(3);
    // R11 poll via secondary
    bw(16'hA0, 8'h0C, 1);
    br(16'hA0, 8'h01, "R11 secondary poll", 1);
    bw(16'h20, 8'h0A, 1);
    br(16'h20, 8'h00, "R11 cascade bit cleared", 1);
    idle(2);
    chk("R11 R12 intr low after poll", 12'(intr_o), 12'h0);
    bw(16'h20, 8'h0C, 1);
    br(16'h20, 8'h07, "R11 empty poll", 1);
    // R13 auto eoi, back-to-back acknowledges
    init(8'h03);
    irq_i[8] = 1'b1; irq_i[9] = 1'b1; idle(4);
    ak(2, 8'h70, 4'd8, 8'h0F, 4'd7, "R5 R8 back-to-back ack");
    idle(3);
    ak(1, 8'h71, 4'd9, 8'h00, 4'd0, "R5 R8 relatched ack");
    bw(16'h20, 8'h0B, 1); br(16'h20, 8'h00, "R13 auto eoi primary", 1);
    bw(16'hA0, 8'h0B, 1); br(16'hA0, 8'h00, "R13 auto eoi secondary", 1);
    irq_i = '0;
    idle(5);
    chk("R1 reads drained", 12'(rd_q.size()), 12'h0);
    chk("R7 vectors drained", 12'(vec_q.size()), 12'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule